// File: doc/BRIEF.md
# Memory Access Fault Exception Encoder

This block watches the load/store stream and the bus-error strobes of a small soft processor core. From them it decides whether a hardware exception must be taken in this cycle. Each cycle it checks the access address against the alignment that the access size needs. It also sorts incoming bus errors into instruction-fetch faults and data-access faults, and each of those two kinds can be switched off by a configuration bit.

When a fault is accepted, the block raises a one-cycle exception request. In the same cycle it presents the exception status word that the core latches into its status register. For an alignment fault, that word packs a cause code, the transfer direction, the register number and a word-size flag into fixed bit positions. When exceptions are disabled, faults are dropped and the status output keeps its previous value. Both outputs are registered, so they follow the stimulus by one clock.

Top module: `mem_fault_encoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `exc_req` is 0 and `exc_status` is all zeros.
- R2: Size encoding on `acc_size` is: 0 = byte (mask 0), 1 = halfword (mask 1), 2 or 3 = word (mask 3). An access with `acc_valid`=1 is misaligned when the address ANDed with its mask is nonzero. With `acc_valid`=0 the address is not checked.
- R3: A byte access never produces an alignment fault, whatever its address.
- R4: The status word of an alignment fault has cause 1 in bits 4:0, `acc_reg` in bits 9:5, `acc_write` in bit 10, and bit 11 set only for a word-size access. All other bits are 0.
- R5: `ibus_err` gives cause 3 (status = 3) unless `cfg_ibus_off` is 1, in which case it is ignored.
- R6: `dbus_err` gives cause 4 (status = 4) unless `cfg_dbus_off` is 1, in which case it is ignored.
- R7: With `exc_enable`=0, no fault raises `exc_req`, and `exc_status` keeps its previous value.
- R8: When several faults are accepted in one cycle, the alignment fault wins over a data bus fault, and a data bus fault wins over an instruction bus fault.
- R9: `exc_req` is high for exactly the cycle after a cycle with an accepted fault, and `exc_status` changes only in such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A load/store is presented this cycle |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | Access size code (0 byte, 1 half, 2/3 word) |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_reg | input | REG_W | Register number of the transfer |
| exc_enable | input | 1 | Exceptions enabled |
| ibus_err | input | 1 | Instruction-fetch bus error strobe |
| dbus_err | input | 1 | Data-access bus error strobe |
| cfg_ibus_off | input | 1 | Suppress instruction bus exceptions |
| cfg_dbus_off | input | 1 | Suppress data bus exceptions |
| exc_req | output | 1 | Registered exception request |
| exc_status | output | STAT_W | Registered exception status word |

## Verification
On every cycle the assertions check four things: nothing is requested when exceptions are disabled; the status is frozen while no request is made; byte accesses never report an alignment cause; and a misaligned access together with a data bus error yields the alignment cause. The exact packing of the register number, direction and size flag, the per-side masking, and the full priority order under mixed fault patterns are shown only by the scoreboard scenarios. Those scenarios compare every output cycle against a model built from the requirements.

// File: rtl/mfe_pkg.sv
package mfe_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_ALIGN = 2'd1,
    FLT_DBUS  = 2'd2,
    FLT_IBUS  = 2'd3
  } fault_e;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_UNALIGNED = 5'd1;
  localparam logic [CAUSE_W-1:0] CAUSE_IBUS      = 5'd3;
  localparam logic [CAUSE_W-1:0] CAUSE_DBUS      = 5'd4;
endpackage

// File: rtl/mfe_align_check.sv
module mfe_align_check
  import mfe_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              misaligned,
  output logic              word_access
);
  localparam int MASK_W = 2;

  logic [MASK_W-1:0] mask;
  logic [ADDR_W-1:0] mask_ext;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE:  mask = 2'b00;
      SZ_HALF:  mask = 2'b01;
      default:  mask = 2'b11;
    endcase
  end

  // Zero-extended so the whole address takes part in the reduction.
  assign mask_ext    = {{(ADDR_W-MASK_W){1'b0}}, mask};
  assign word_access = (mask == 2'b11);
  assign misaligned  = valid && (|(addr & mask_ext));
endmodule

// File: rtl/mfe_bus_classify.sv
module mfe_bus_classify (
  input  logic ibus_err,
  input  logic dbus_err,
  input  logic ibus_off,
  input  logic dbus_off,
  output logic ibus_fault,
  output logic dbus_fault
);
  assign ibus_fault = ibus_err && !ibus_off;
  assign dbus_fault = dbus_err && !dbus_off;
endmodule

// File: rtl/mfe_status_pack.sv
module mfe_status_pack
  import mfe_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              enable,
  input  logic              align_fault,
  input  logic              word_access,
  input  logic              write,
  input  logic [REG_W-1:0]  reg_num,
  input  logic              dbus_fault,
  input  logic              ibus_fault,
  output logic              fire,
  output logic [STAT_W-1:0] status
);
  localparam int REG_LSB  = CAUSE_W;
  localparam int WR_BIT   = REG_LSB + REG_W;
  localparam int WORD_BIT = WR_BIT + 1;

  fault_e kind;

  // Fixed priority: alignment, then data bus, then instruction bus.
  always_comb begin
    if (!enable)          kind = FLT_NONE;
    else if (align_fault) kind = FLT_ALIGN;
    else if (dbus_fault)  kind = FLT_DBUS;
    else if (ibus_fault)  kind = FLT_IBUS;
    else                  kind = FLT_NONE;
  end

  always_comb begin
    status = '0;
    unique case (kind)
      FLT_ALIGN: begin
        status[CAUSE_W-1:0]            = CAUSE_UNALIGNED;
        status[REG_LSB +: REG_W]       = reg_num;
        status[WR_BIT]                 = write;
        status[WORD_BIT]               = word_access;
      end
      FLT_DBUS:  status[CAUSE_W-1:0]   = CAUSE_DBUS;
      FLT_IBUS:  status[CAUSE_W-1:0]   = CAUSE_IBUS;
      default:   status                = '0;
    endcase
  end

  assign fire = (kind != FLT_NONE);
endmodule

// File: rtl/mem_fault_encoder.sv
module mem_fault_encoder
  import mfe_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int REG_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_size,
  input  logic              acc_write,
  input  logic [REG_W-1:0]  acc_reg,
  input  logic              exc_enable,
  input  logic              ibus_err,
  input  logic              dbus_err,
  input  logic              cfg_ibus_off,
  input  logic              cfg_dbus_off,
  output logic              exc_req,
  output logic [STAT_W-1:0] exc_status
);
  logic              misaligned;
  logic              word_access;
  logic              ibus_fault;
  logic              dbus_fault;
  logic              fire;
  logic [STAT_W-1:0] status_next;

  mfe_align_check #(.ADDR_W(ADDR_W)) u_align (
    .valid       (acc_valid),
    .addr        (acc_addr),
    .size        (acc_size),
    .misaligned  (misaligned),
    .word_access (word_access)
  );

  mfe_bus_classify u_bus (
    .ibus_err   (ibus_err),
    .dbus_err   (dbus_err),
    .ibus_off   (cfg_ibus_off),
    .dbus_off   (cfg_dbus_off),
    .ibus_fault (ibus_fault),
    .dbus_fault (dbus_fault)
  );

  mfe_status_pack #(.STAT_W(STAT_W), .REG_W(REG_W)) u_pack (
    .enable      (exc_enable),
    .align_fault (misaligned),
    .word_access (word_access),
    .write       (acc_write),
    .reg_num     (acc_reg),
    .dbus_fault  (dbus_fault),
    .ibus_fault  (ibus_fault),
    .fire        (fire),
    .status      (status_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_req    <= 1'b0;
      exc_status <= '0;
    end else begin
      exc_req <= fire;
      if (fire) exc_status <= status_next;
    end
  end
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker #(
  parameter int ADDR_W = 32,
  parameter int STAT_W = 32,
  parameter int REG_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [1:0]        acc_size,
  input logic              exc_enable,
  input logic              dbus_err,
  input logic              exc_req,
  input logic [STAT_W-1:0] exc_status
);
  logic bad_align;
  assign bad_align = acc_valid &&
                     (((acc_size == 2'd1) && acc_addr[0]) ||
                      ((acc_size[1]) && (acc_addr[1:0] != 2'b00)));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !exc_enable |=> !exc_req);

  p_status_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !exc_req |-> $stable(exc_status));

  p_byte_never_unaligned_r3: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_size == 2'd0) |=> !(exc_req && exc_status[4:0] == 5'd1));

  p_align_beats_dbus_r8: assert property (@(posedge clk) disable iff (rst)
    (exc_enable && bad_align && dbus_err) |=> (exc_req && exc_status[4:0] == 5'd1));
endmodule

bind mem_fault_encoder mfe_checker #(
  .ADDR_W(ADDR_W), .STAT_W(STAT_W), .REG_W(REG_W)
) u_mfe_checker (
  .clk        (clk),
  .rst        (rst),
  .acc_valid  (acc_valid),
  .acc_addr   (acc_addr),
  .acc_size   (acc_size),
  .exc_enable (exc_enable),
  .dbus_err   (dbus_err),
  .exc_req    (exc_req),
  .exc_status (exc_status)
);

// File: tb/test_mem_fault_encoder.sv
`timescale 1ns/1ps
module test_mem_fault_encoder;
  localparam int ADDR_W = 32;
  localparam int STAT_W = 32;
  localparam int REG_W  = 5;

  logic              clk = 1'b0;
  logic              rst;
  logic              acc_valid, acc_write, exc_enable;
  logic [ADDR_W-1:0] acc_addr;
  logic [1:0]        acc_size;
  logic [REG_W-1:0]  acc_reg;
  logic              ibus_err, dbus_err, cfg_ibus_off, cfg_dbus_off;
  logic              exc_req;
  logic [STAT_W-1:0] exc_status;

  always #10 clk = ~clk;

  mem_fault_encoder #(.ADDR_W(ADDR_W), .STAT_W(STAT_W), .REG_W(REG_W)) i_mem_fault_encoder (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_size(acc_size), .acc_write(acc_write), .acc_reg(acc_reg),
    .exc_enable(exc_enable), .ibus_err(ibus_err), .dbus_err(dbus_err),
    .cfg_ibus_off(cfg_ibus_off), .cfg_dbus_off(cfg_dbus_off),
    .exc_req(exc_req), .exc_status(exc_status)
  );

  typedef struct {
    logic              req;
    logic [STAT_W-1:0] status;
    string             tag;
  } exp_t;

  exp_t              sb[$];
  int                checks = 0;
  int                errors = 0;
  logic [STAT_W-1:0] model_status = '0;
  bit                done = 0;

  // Driver: apply one cycle of stimulus, push the expected result.
  task automatic drive(input logic v, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                       input logic wr, input logic [REG_W-1:0] rn, input logic en,
                       input logic ie, input logic de, input logic ioff, input logic doff,
                       input string tag);
    exp_t e;
    logic mis, word;
    logic [1:0] m;
    @(negedge clk);
    acc_valid = v; acc_addr = a; acc_size = sz; acc_write = wr; acc_reg = rn;
    exc_enable = en; ibus_err = ie; dbus_err = de; cfg_ibus_off = ioff; cfg_dbus_off = doff;
    m    = (sz == 2'd0) ? 2'b00 : (sz == 2'd1) ? 2'b01 : 2'b11;
    word = (m == 2'b11);
    mis  = v && ((a[1:0] & m) != 2'b00);
    e.req = 1'b0;
    if (en) begin
      if (mis) begin
        e.req = 1'b1;
        model_status = {20'd0, word, wr, rn, 5'd1};
      end else if (de && !doff) begin
        e.req = 1'b1;
        model_status = 32'd4;
      end else if (ie && !ioff) begin
        e.req = 1'b1;
        model_status = 32'd3;
      end
    end
    e.status = model_status;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 2'd0, 1'b0, '0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compare design outputs after each capturing edge.
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (exc_req !== e.req || exc_status !== e.status) begin
        errors++;
        $display("FAIL %s: got req=%0b status=%h, expected req=%0b status=%h",
                 e.tag, exc_req, exc_status, e.req, e.status);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    acc_valid = 0; acc_addr = '0; acc_size = 0; acc_write = 0; acc_reg = '0;
    exc_enable = 0; ibus_err = 0; dbus_err = 0; cfg_ibus_off = 0; cfg_dbus_off = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (exc_req !== 1'b0 || exc_status !== '0) begin
      errors++;
      $display("FAIL R1 reset: got req=%0b status=%h, expected req=0 status=0", exc_req, exc_status);
    end
    rst = 1'b0;
    idle("R1 first cycle after reset");

    // R2/R3/R4: sweep sizes over low address patterns
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 8; a++)
        drive(1'b1, 32'h1000_0000 | a, s[1:0], a[0], 5'(a * 3 + s), 1'b1,
              1'b0, 1'b0, 1'b0, 1'b0, "R2 R3 R4 size/address sweep");

    drive(1'b1, 32'hFFFF_FFFF, 2'd0, 1'b1, 5'd31, 1'b1, 0, 0, 0, 0, "R3 byte at odd address");
    drive(1'b1, 32'h0000_0003, 2'd1, 1'b1, 5'd17, 1'b1, 0, 0, 0, 0, "R4 halfword store fields");
    drive(1'b1, 32'h0000_0002, 2'd2, 1'b0, 5'd9,  1'b1, 0, 0, 0, 0, "R4 word load word flag");
    drive(1'b0, 32'h0000_0001, 2'd2, 1'b1, 5'd5,  1'b1, 0, 0, 0, 0, "R2 invalid access not checked");

    // R7: disabled exceptions ignore everything; status held
    drive(1'b1, 32'h0000_0001, 2'd2, 1'b1, 5'd3, 1'b0, 1, 1, 0, 0, "R7 all faults while disabled");
    idle("R7 status still held");

    // R5 / R6 with masking
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 1, 0, 0, 0, "R5 instruction bus error");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 1, 0, 1, 0, "R5 instruction bus masked");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 0, 1, 0, 0, "R6 data bus error");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 0, 1, 0, 1, "R6 data bus masked");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 1, 0, 0, 1, "R5 ibus with dbus mask set");

    // R8 priority
    drive(1'b1, 32'h0000_0006, 2'd3, 1'b1, 5'd12, 1'b1, 1, 1, 0, 0, "R8 align over dbus and ibus");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 1, 1, 0, 0, "R8 dbus over ibus");
    drive(1'b0, '0, 2'd0, 0, '0, 1'b1, 1, 1, 0, 1, "R8 masked dbus lets ibus through");
    drive(1'b1, 32'h0000_0001, 2'd0, 0, 5'd2, 1'b1, 0, 1, 0, 0, "R8 R3 byte plus dbus gives dbus");

    // R9: pulse lasts a single cycle, status held across idle cycles
    drive(1'b1, 32'h0000_0001, 2'd1, 0, 5'd30, 1'b1, 0, 0, 0, 0, "R9 fault pulse");
    idle("R9 pulse ends, status held");
    idle("R9 status held again");

    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule